// File: doc/BRIEF.md
# Banked Memory Window Mapper

This mapper sits between a CPU with a 16-bit address space and a large paged ROM plus one small shared RAM. The lower 48 kB of the address space is split into six 8 kB windows. Each window has its own 8-bit page register. The value in that register decides what the window shows: a ROM page, the shared 8 kB RAM, or nothing at all. Software moves a window by writing a page number into a register window that lies inside the address space. The registers for the six windows sit at 1 kB steps whose order does not follow window order.

A control byte can open a small readback window. While it is open, software reads the six page registers back from fixed addresses, and these reads take precedence over whatever the window underneath holds. Reads and mapping decisions are combinational from the current registers. A register write takes effect on the clock edge on which it is presented. The ROM and RAM are external: the mapper drives a 20-bit ROM byte address and a 13-bit RAM byte address with a write strobe, and selects which returned byte reaches the CPU.

Top module: `bank_window_mapper`

## Requirements
- R1: A write to 0x6000–0x7FEF loads a page register chosen by address bits [12:10]: code 0 loads window 2, 1 loads window 0, 2 loads window 3, 3 loads window 1, 4 loads window 4 and 6 loads window 5. Codes 5 and 7 leave every page register unchanged.
- R2: After reset every page register holds 0xA8 and the control byte holds 0x00, so each window shows ROM page 0x28.
- R3: A page value outside 0x80–0x8F maps ROM page (value & 0x7F). A read in that window drives rom_addr = {page[6:0], addr[12:0]} and returns rom_rdata, so values 0x90–0xFF mirror pages 0x10–0x7F.
- R4: A page value in 0x80–0x8F with bit 2 set maps the shared RAM. Reads return ram_rdata from offset addr[12:0], and all such windows see the same RAM.
- R5: A page value in 0x80–0x8F with bit 2 clear makes the window read 0xFF, and writes to it leave the RAM unchanged.
- R6: A write to 0x7FF9 stores the control byte. While its bit 2 is set, reads of 0x7FF0–0x7FF5 return page registers 0–5, and reads of 0x7FF6–0x7FF7 return 0x00. This takes priority over the window contents.
- R7: While control bit 2 is clear, reads of 0x7FF0–0x7FF7 return the contents of the window mapped there.
- R8: Reads at 0xC000–0xFFFF return 0xFF, and writes there never assert ram_we.
- R9: A write to a RAM-mapped window stores cpu_wdata at RAM offset addr[12:0] on that clock edge. Writes to 0x6000–0x7FEF and to 0x7FF9 never reach RAM.
- R10: A page register written on a clock edge governs reads in the very next cycle.
- R11: cpu_rdata reads 0xFF whenever cpu_rd is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe, acted on at the clock edge |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| rom_addr | output | 20 | ROM byte address: page and offset |
| rom_rdata | input | 8 | ROM data for rom_addr |
| ram_addr | output | 13 | Shared RAM byte offset |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM data for ram_addr |

## Verification
A page register holding a wrong value shows up the first time its window is read. The read returns a different ROM page, RAM instead of ROM, or 0xFF, in the cycle right after the faulty write. It also shows up through the readback window, which exposes all six registers directly once the control bit is set. A wrong decode of the scrambled register order moves a neighbouring window instead of the intended one, so the bench checks every window after each batch of writes. A write that wrongly reaches RAM is caught by reading that RAM offset back later through a RAM-mapped window.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  localparam int ADDR_W       = 16;
  localparam int DATA_W       = 8;
  localparam int OFFSET_W     = 13;
  localparam int REGION_IDX_W = ADDR_W - OFFSET_W;
  localparam int REGION_SLOTS = 1 << REGION_IDX_W;

  localparam logic [ADDR_W-1:0] REG_WIN_LO = 16'h6000;
  localparam logic [ADDR_W-1:0] REG_WIN_HI = 16'h7FEF;
  localparam logic [ADDR_W-1:0] CTRL_ADDR  = 16'h7FF9;
  localparam logic [ADDR_W-1:0] RB_BASE    = 16'h7FF0;
  localparam int                RB_ENA_BIT = 2;

  typedef enum logic [1:0] {
    WIN_ROM  = 2'd0,
    WIN_RAM  = 2'd1,
    WIN_VOID = 2'd2
  } win_kind_e;

  typedef struct packed {
    logic                    hit;
    logic [REGION_IDX_W-1:0] region;
  } sel_map_t;

  // register-select code (address bits 12:10) to window index
  function automatic sel_map_t map_select(input logic [2:0] code);
    sel_map_t m;
    m.hit = 1'b1;
    unique case (code)
      3'd0:    m.region = 3'd2;
      3'd1:    m.region = 3'd0;
      3'd2:    m.region = 3'd3;
      3'd3:    m.region = 3'd1;
      3'd4:    m.region = 3'd4;
      3'd6:    m.region = 3'd5;
      default: begin
        m.hit    = 1'b0;
        m.region = 3'd0;
      end
    endcase
    return m;
  endfunction

endpackage

// File: rtl/bwm_rst_sync.sv
module bwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb shift_d = {shift_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_n_sync = shift_q[STAGES-1];
endmodule

// File: rtl/bwm_bank_file.sv
module bwm_bank_file
  import bwm_pkg::*;
#(
  parameter int                NUM_REGIONS = 6,
  parameter int                BANK_W      = 8,
  parameter logic [BANK_W-1:0] RESET_BANK  = 8'hA8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bank_we,
  input  logic [REGION_IDX_W-1:0]           bank_idx,
  input  logic [BANK_W-1:0]                 bank_wdata,
  input  logic                              ctrl_we,
  input  logic [DATA_W-1:0]                 ctrl_wdata,
  output logic [NUM_REGIONS-1:0][BANK_W-1:0] bank_q,
  output logic [DATA_W-1:0]                 ctrl_q
);
  logic [DATA_W-1:0] ctrl_d;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_bank
    logic              en;
    logic [BANK_W-1:0] d;
    always_comb begin
      en = bank_we && (bank_idx == REGION_IDX_W'(g));
      d  = en ? bank_wdata : bank_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q[g] <= RESET_BANK;
      else        bank_q[g] <= d;
    end
  end

  always_comb ctrl_d = ctrl_we ? ctrl_wdata : ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/bwm_page_decode.sv
module bwm_page_decode
  import bwm_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int PAGE_W = 7
) (
  input  logic [BANK_W-1:0] bank,
  output win_kind_e         kind,
  output logic [PAGE_W-1:0] page
);
  always_comb begin
    page = bank[PAGE_W-1:0];
    if (bank[BANK_W-1:BANK_W-4] == 4'h8)
      kind = bank[2] ? WIN_RAM : WIN_VOID;
    else
      kind = WIN_ROM;
  end
endmodule

// File: rtl/bwm_read_select.sv
module bwm_read_select
  import bwm_pkg::*;
(
  input  logic              cpu_rd,
  input  logic              rb_hit,
  input  logic [DATA_W-1:0] rb_data,
  input  win_kind_e         kind,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] cpu_rdata
);
  always_comb begin
    if (!cpu_rd)                 cpu_rdata = '1;
    else if (rb_hit)             cpu_rdata = rb_data;
    else if (kind == WIN_RAM)    cpu_rdata = ram_rdata;
    else if (kind == WIN_ROM)    cpu_rdata = rom_rdata;
    else                         cpu_rdata = '1;
  end
endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper
  import bwm_pkg::*;
#(
  parameter int                NUM_REGIONS = 6,
  parameter int                BANK_W      = 8,
  parameter int                PAGE_W      = 7,
  parameter logic [BANK_W-1:0] RESET_BANK  = 8'hA8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic [DATA_W-1:0]          cpu_wdata,
  input  logic                       cpu_rd,
  input  logic                       cpu_wr,
  output logic [DATA_W-1:0]          cpu_rdata,
  output logic [PAGE_W+OFFSET_W-1:0] rom_addr,
  input  logic [DATA_W-1:0]          rom_rdata,
  output logic [OFFSET_W-1:0]        ram_addr,
  output logic                       ram_we,
  output logic [DATA_W-1:0]          ram_wdata,
  input  logic [DATA_W-1:0]          ram_rdata
);
  logic                               rst_n_sync;
  logic [NUM_REGIONS-1:0][BANK_W-1:0] bank_q;
  logic [NUM_REGIONS*BANK_W-1:0]      bank_flat;
  logic [DATA_W-1:0]                  ctrl_q;

  logic [REGION_IDX_W-1:0] region;
  logic                    in_reg_win;
  logic                    ctrl_hit;
  sel_map_t                sel;
  logic                    bank_we;
  logic                    ctrl_we;
  logic                    rb_hit;

  win_kind_e               kind_pad [REGION_SLOTS];
  logic [PAGE_W-1:0]       page_pad [REGION_SLOTS];
  logic [DATA_W-1:0]       rb_pad   [REGION_SLOTS];
  win_kind_e               cur_kind;
  logic [PAGE_W-1:0]       cur_page;

  bwm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  // address decode
  always_comb begin
    region     = cpu_addr[ADDR_W-1:OFFSET_W];
    in_reg_win = (cpu_addr >= REG_WIN_LO) && (cpu_addr <= REG_WIN_HI);
    ctrl_hit   = (cpu_addr == CTRL_ADDR);
    sel        = map_select(cpu_addr[12:10]);
    bank_we    = cpu_wr && in_reg_win && sel.hit;
    ctrl_we    = cpu_wr && ctrl_hit;
    rb_hit     = ctrl_q[RB_ENA_BIT] && (cpu_addr[ADDR_W-1:3] == RB_BASE[ADDR_W-1:3]);
  end

  bwm_bank_file #(
    .NUM_REGIONS (NUM_REGIONS),
    .BANK_W      (BANK_W),
    .RESET_BANK  (RESET_BANK)
  ) u_banks (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .bank_we    (bank_we),
    .bank_idx   (sel.region),
    .bank_wdata (cpu_wdata),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (cpu_wdata),
    .bank_q     (bank_q),
    .ctrl_q     (ctrl_q)
  );

  // per-slot decode, padded to the full 3-bit region index
  for (genvar g = 0; g < REGION_SLOTS; g++) begin : g_slot
    if (g < NUM_REGIONS) begin : g_live
      bwm_page_decode #(.BANK_W(BANK_W), .PAGE_W(PAGE_W)) u_dec (
        .bank (bank_q[g]),
        .kind (kind_pad[g]),
        .page (page_pad[g])
      );
      assign rb_pad[g] = DATA_W'(bank_q[g]);
      assign bank_flat[g*BANK_W +: BANK_W] = bank_q[g];
    end else begin : g_dead
      assign kind_pad[g] = WIN_VOID;
      assign page_pad[g] = '0;
      assign rb_pad[g]   = '0;
    end
  end

  always_comb begin
    cur_kind  = kind_pad[region];
    cur_page  = page_pad[region];
    rom_addr  = {cur_page, cpu_addr[OFFSET_W-1:0]};
    ram_addr  = cpu_addr[OFFSET_W-1:0];
    ram_wdata = cpu_wdata;
    ram_we    = cpu_wr && !in_reg_win && !ctrl_hit && (cur_kind == WIN_RAM);
  end

  bwm_read_select u_rsel (
    .cpu_rd    (cpu_rd),
    .rb_hit    (rb_hit),
    .rb_data   (rb_pad[cpu_addr[2:0]]),
    .kind      (cur_kind),
    .rom_rdata (rom_rdata),
    .ram_rdata (ram_rdata),
    .cpu_rdata (cpu_rdata)
  );
endmodule

// File: rtl/bwm_checker.sv
module bwm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic [7:0]  cpu_rdata,
  input logic        ram_we,
  input logic [47:0] bank_flat,
  input logic [7:0]  ctrl_q
);
  logic [63:0] bank_pad;
  logic        in_win;
  logic [7:0]  cur_bank;
  logic [7:0]  rb_bank;

  always_comb begin
    bank_pad = {16'h0000, bank_flat};
    in_win   = (cpu_addr >= 16'h6000) && (cpu_addr <= 16'h7FEF);
    cur_bank = bank_pad[cpu_addr[15:13]*8 +: 8];
    rb_bank  = bank_pad[cpu_addr[2:0]*8 +: 8];
  end

  assert_reset_state_R2: assert property (@(posedge clk)
    $rose(rst_n) |-> (bank_flat == {6{8'hA8}}) && (ctrl_q == 8'h00));

  assert_dead_codes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && in_win && (cpu_addr[12:10] == 3'd5 || cpu_addr[12:10] == 3'd7)
    |=> $stable(bank_flat));

  assert_code0_window2_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && in_win && (cpu_addr[12:10] == 3'd0)
    |=> bank_flat[23:16] == $past(cpu_wdata));

  assert_ctrl_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && (cpu_addr == 16'h7FF9) |=> ctrl_q == $past(cpu_wdata));

  assert_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && ctrl_q[2] && (cpu_addr[15:3] == 13'h0FFE) |-> cpu_rdata == rb_bank);

  assert_high_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && (cpu_addr[15:14] == 2'b11) |-> cpu_rdata == 8'hFF);

  assert_high_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b11) |-> !ram_we);

  assert_ram_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> cpu_wr && !in_win && (cpu_addr != 16'h7FF9));

  assert_ram_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (cur_bank & 8'hF4) == 8'h84);

  assert_idle_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |-> cpu_rdata == 8'hFF);
endmodule

bind bank_window_mapper bwm_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_rd    (cpu_rd),
  .cpu_wr    (cpu_wr),
  .cpu_rdata (cpu_rdata),
  .ram_we    (ram_we),
  .bank_flat (bank_flat),
  .ctrl_q    (ctrl_q)
);

// File: tb/sim_bank_window_mapper.sv
`timescale 1ns/1ps
module sim_bank_window_mapper;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_rd;
  logic        cpu_wr;
  logic [7:0]  cpu_rdata;
  logic [19:0] rom_addr;
  logic [7:0]  rom_rdata;
  logic [12:0] ram_addr;
  logic        ram_we;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata;

  logic [7:0]  ram_mem [8192];
  int          checks = 0;
  int          errors = 0;
  logic        last_we;

  always #10 clk = ~clk;

  bank_window_mapper u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata), .ram_addr(ram_addr),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // memory models
  assign rom_rdata = rom_addr[19:12] ^ rom_addr[7:0];
  assign ram_rdata = ram_mem[ram_addr];
  always @(posedge clk) if (ram_we) ram_mem[ram_addr] <= ram_wdata;

  function automatic logic [7:0] rom_exp(input logic [6:0] page, input logic [15:0] a);
    return {page, a[12]} ^ a[7:0];
  endfunction

  function automatic logic [7:0] ram_init(input int i);
    return 8'(i) ^ 8'hC3;
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    #5 last_we = ram_we;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wr = 1'b0; cpu_rd = 1'b1;
    #5 d = cpu_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    cpu_read(16'h0000, v); check("R2", "window0 page", v, rom_exp(7'h28, 16'h0000));
    cpu_read(16'hA345, v); check("R2", "window5 page", v, rom_exp(7'h28, 16'hA345));
    cpu_read(16'h7FF0, v); check("R2", "control clear", v, rom_exp(7'h28, 16'h7FF0));
    cpu_write(16'h7FF9, 8'h04);
    for (int i = 0; i < 8; i++) begin
      cpu_read(16'h7FF0 + 16'(i), v);
      check("R2", "readback reset", v, (i < 6) ? 8'hA8 : 8'h00);
    end
    cpu_write(16'h7FF9, 8'h00);
    @(negedge clk); cpu_rd = 1'b0;
    #5 check("R11", "idle read", cpu_rdata, 8'hFF);
  endtask

  task automatic t_decode;
    logic [7:0] v;
    logic [7:0] exp_bank [6];
    cpu_write(16'h6000, 8'h01);
    cpu_read(16'h4123, v); check("R10", "next-cycle map", v, rom_exp(7'h01, 16'h4123));
    cpu_write(16'h6400, 8'h02);
    cpu_write(16'h6800, 8'h03);
    cpu_write(16'h6C00, 8'h04);
    cpu_write(16'h7000, 8'h05);
    cpu_write(16'h7800, 8'h06);
    cpu_write(16'h7400, 8'h11);
    cpu_write(16'h7C10, 8'h12);
    exp_bank = '{8'h02, 8'h04, 8'h01, 8'h03, 8'h05, 8'h06};
    for (int r = 0; r < 6; r++) begin
      cpu_read(16'(r) << 13 | 16'h0077, v);
      check("R1", "scrambled decode", v, rom_exp(exp_bank[r][6:0], 16'(r) << 13 | 16'h0077));
    end
    cpu_write(16'h7FF9, 8'h04);
    for (int i = 0; i < 8; i++) begin
      cpu_read(16'h7FF0 + 16'(i), v);
      check("R6", "readback", v, (i < 6) ? exp_bank[i] : 8'h00);
    end
    cpu_write(16'h7FF9, 8'h00);
  endtask

  task automatic t_mirror;
    logic [7:0] v;
    cpu_write(16'h6400, 8'h95);
    cpu_read(16'h0042, v); check("R3", "mirror 0x95", v, rom_exp(7'h15, 16'h0042));
    cpu_write(16'h6400, 8'h7F);
    cpu_read(16'h1FFE, v); check("R3", "page 0x7F", v, rom_exp(7'h7F, 16'h1FFE));
    cpu_write(16'h6400, 8'h90);
    cpu_read(16'h0100, v); check("R3", "mirror 0x90", v, rom_exp(7'h10, 16'h0100));
  endtask

  task automatic t_ram;
    logic [7:0] v;
    cpu_write(16'h6C00, 8'h84);
    cpu_write(16'h2010, 8'h3C);
    check("R9", "ram_we on RAM write", 8'(last_we), 8'h01);
    cpu_read(16'h2010, v); check("R4", "RAM read", v, 8'h3C);
    cpu_write(16'h7000, 8'h8C);
    cpu_read(16'h8010, v); check("R4", "shared RAM", v, 8'h3C);
  endtask

  task automatic t_void;
    logic [7:0] v;
    cpu_write(16'h7800, 8'h80);
    cpu_read(16'hA000, v); check("R5", "void read", v, 8'hFF);
    cpu_write(16'hA020, 8'h77);
    check("R5", "void write no ram_we", 8'(last_we), 8'h00);
    cpu_write(16'h7800, 8'h8B);
    cpu_read(16'hA021, v); check("R5", "void 0x8B", v, 8'hFF);
    cpu_write(16'h7800, 8'h87);
    cpu_read(16'hA020, v); check("R5", "RAM untouched", v, ram_init(16'h0020));
  endtask

  task automatic t_window3;
    logic [7:0] v;
    cpu_write(16'h6800, 8'h84);
    cpu_write(16'h6030, 8'h86);
    cpu_read(16'h6030, v); check("R9", "register write not in RAM", v, ram_init(16'h0030));
    cpu_write(16'h7FF2, 8'h5A);
    cpu_read(16'h7FF2, v); check("R7", "readback off shows RAM", v, 8'h5A);
    cpu_write(16'h7FF9, 8'h04);
    cpu_read(16'h7FF2, v); check("R6", "readback priority", v, 8'h86);
    cpu_read(16'h7FF9, v); check("R9", "control write not in RAM", v, ram_init(16'h1FF9));
    cpu_write(16'h7FF9, 8'h00);
  endtask

  task automatic t_high;
    logic [7:0] v;
    cpu_read(16'hC000, v); check("R8", "read C000", v, 8'hFF);
    cpu_read(16'hFFFF, v); check("R8", "read FFFF", v, 8'hFF);
    cpu_write(16'hE010, 8'h99);
    check("R8", "high write no ram_we", 8'(last_we), 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 8192; i++) ram_mem[i] = ram_init(i);
    rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_rd = 1'b0; cpu_wr = 1'b0; last_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_decode();
    t_mirror();
    t_ram();
    t_void();
    t_window3();
    t_high();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule